// File: doc/BRIEF.md
# Audio control command decoder

This block turns the stream of bytes delivered by a serial bus slave into the settings of an audio processor. Each byte carries a variable-length prefix that names its target: volume, one of four speaker attenuators, input selection with input gain, bass, or treble. The bytes are applied in the order they arrive, and each one rewrites only its own target. A byte is accepted on any cycle in which its strobe is high.

Every setting is brought out twice. One output is the raw field as it was received. The other is a signed level in quarter-decibel units, so that downstream logic never has to decode the coarse-plus-fine attenuation code or the sign-magnitude tone code. The block also gives a mute flag for each speaker. It raises a one-cycle error pulse when an input-select byte names an input that does not exist, and a one-cycle pulse whenever any stored setting takes a new value.

Top module: `audio_cmd_decoder`

## Requirements
- R1: A byte 00BBBAAA stores BBBAAA as the volume code, and the volume level is -(40*B + 5*A) quarter-dB, which spans 0 to -315.
- R2: A byte 1PPBBAAA stores BBAAA as the code of speaker PP, where 0 = left front, 1 = right front, 2 = left rear and 3 = right rear. The code of speaker n sits at bits [5n+4:5n] of the code output, and its level, -(40*B + 5*A) quarter-dB, is a signed 10-bit field at bits [10n+9:10n]. The other speakers keep their values.
- R3: A speaker code of 11111 raises that speaker's mute flag (bit n) and gives a level of 0. Any other code clears the flag.
- R4: A byte 010GGSSS with SSS from 0 to 4 stores SSS as the input select (0 = input 1 ... 4 = input 5) and GG as the gain code. The gain level is 25*(3-GG) quarter-dB, so 00 gives +75 and 11 gives 0.
- R5: A byte 0110CCCC stores CCCC as the bass code, and a byte 0111CCCC stores it as the treble code.
- R6: A tone code with C3 = 0 gives 8*C - 56 quarter-dB (-56 to 0). A tone code with C3 = 1 gives 8*(15 - C) quarter-dB (0 to +56).
- R7: During reset and after it, the volume code is 111110 (-310), each speaker code is 11110 (-150, not muted), the select is 4, the gain code is 11, and the bass and treble codes are 1110 (+8). Both pulses are low.
- R8: An input-select byte with SSS of 5, 6 or 7 leaves the select and the gain unchanged and raises the error output for one cycle.
- R9: Settings change only on a cycle with the strobe high. Bytes on consecutive cycles are each applied, in arrival order.
- R10: The change pulse is high for one cycle when a byte alters a stored setting. It stays low when a byte rewrites a value that is already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Strobe for one received byte |
| byte_data | input | 8 | Received byte |
| vol_code | output | 6 | Raw volume code |
| vol_att | output | 10 | Volume level, signed quarter-dB |
| spk_code | output | 20 | Four 5-bit speaker codes |
| spk_att | output | 40 | Four signed 10-bit speaker levels |
| spk_mute | output | 4 | Per-speaker mute flags |
| in_sel | output | 3 | Selected input, 0 to 4 |
| gain_code | output | 2 | Raw input gain code |
| gain_lvl | output | 10 | Input gain, signed quarter-dB |
| bass_code | output | 4 | Raw bass code |
| bass_lvl | output | 10 | Bass level, signed quarter-dB |
| treble_code | output | 4 | Raw treble code |
| treble_lvl | output | 10 | Treble level, signed quarter-dB |
| sel_err | output | 1 | One-cycle pulse on an illegal input select |
| changed | output | 1 | One-cycle pulse when a setting changes |

## Verification
A byte strobed at one rising edge shows up in its raw code at that same edge, and the level outputs follow it through logic alone. The error and change pulses are registered at the same edge, so they are high during exactly the cycle that follows it. The bench drives each byte on a falling edge and reads every result on the next falling edge. It then reads the pulses once more one cycle later, to confirm that they have dropped. For back-to-back bytes, it waits until after the last strobe before checking the final state.

// File: rtl/acd_pkg.sv
package acd_pkg;
    localparam int NUM_SPK = 4;
    localparam int VOL_W   = 6;
    localparam int SPK_W   = 5;
    localparam int SEL_W   = 3;
    localparam int GAIN_W  = 2;
    localparam int TONE_W  = 4;
    localparam int SEL_MAX = 4;

    typedef struct packed {
        logic [VOL_W-1:0]                vol;
        logic [NUM_SPK-1:0][SPK_W-1:0]   spk;
        logic [SEL_W-1:0]                sel;
        logic [GAIN_W-1:0]               gain;
        logic [TONE_W-1:0]               bass;
        logic [TONE_W-1:0]               treb;
    } settings_t;

    localparam settings_t SET_RESET = '{
        vol:  6'b111110,
        spk:  {NUM_SPK{5'b11110}},
        sel:  3'd4,
        gain: 2'b11,
        bass: 4'b1110,
        treb: 4'b1110
    };
endpackage

// File: rtl/acd_regfile.sv
module acd_regfile
    import acd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_valid,
    input  logic [7:0] byte_data,
    output settings_t set_o,
    output logic      err_o,
    output logic      chg_o
);
    typedef struct packed {
        settings_t set;
        logic      err;
        logic      chg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (byte_valid) begin
            casez (byte_data)
                8'b1???????: st_d.set.spk[byte_data[6:5]] = byte_data[4:0];
                8'b00??????: st_d.set.vol = byte_data[5:0];
                8'b010?????: begin
                    if (int'(byte_data[2:0]) <= SEL_MAX) begin
                        st_d.set.sel  = byte_data[2:0];
                        st_d.set.gain = byte_data[4:3];
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                8'b0110????: st_d.set.bass = byte_data[3:0];
                default:     st_d.set.treb = byte_data[3:0];
            endcase
        end
        st_d.chg = (st_d.set != st_q.set);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{set: SET_RESET, err: 1'b0, chg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign set_o = st_q.set;
    assign err_o = st_q.err;
    assign chg_o = st_q.chg;

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(set_o));
    p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(set_o.sel) <= SEL_MAX);
    p_err_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable({set_o.sel, set_o.gain}));
    p_chg_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(set_o) |-> chg_o);
endmodule

// File: rtl/acd_att_conv.sv
module acd_att_conv #(
    parameter int COARSE_W = 3,
    parameter int FINE_W   = 3,
    parameter int COARSE_Q = 40,
    parameter int FINE_Q   = 5,
    parameter int ATT_W    = 10
) (
    input  logic [COARSE_W+FINE_W-1:0] code_i,
    output logic [ATT_W-1:0]           att_o
);
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;

    assign coarse = code_i[COARSE_W+FINE_W-1:FINE_W];
    assign fine   = code_i[FINE_W-1:0];
    assign att_o  = ATT_W'(-(int'(coarse) * COARSE_Q + int'(fine) * FINE_Q));
endmodule

// File: rtl/acd_tone_conv.sv
module acd_tone_conv #(
    parameter int STEP_Q = 8,
    parameter int ATT_W  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] code_i,
    output logic [ATT_W-1:0] lvl_o
);
    int lvl_i;

    always_comb begin
        if (code_i[3]) lvl_i = (15 - int'(code_i)) * STEP_Q;
        else           lvl_i = (int'(code_i) - 7) * STEP_Q;
    end
    assign lvl_o = ATT_W'(lvl_i);

    p_tone_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(lvl_o) <= 7 * STEP_Q) && ($signed(lvl_o) >= -7 * STEP_Q));
endmodule

// File: rtl/audio_cmd_decoder.sv
module audio_cmd_decoder
    import acd_pkg::*;
#(
    parameter int ATT_W    = 10,
    parameter int FINE_Q   = 5,
    parameter int COARSE_Q = 40,
    parameter int TONE_Q   = 8,
    parameter int GAIN_Q   = 25
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_valid,
    input  logic [7:0]                 byte_data,
    output logic [VOL_W-1:0]           vol_code,
    output logic [ATT_W-1:0]           vol_att,
    output logic [NUM_SPK*SPK_W-1:0]   spk_code,
    output logic [NUM_SPK*ATT_W-1:0]   spk_att,
    output logic [NUM_SPK-1:0]         spk_mute,
    output logic [SEL_W-1:0]           in_sel,
    output logic [GAIN_W-1:0]          gain_code,
    output logic [ATT_W-1:0]           gain_lvl,
    output logic [TONE_W-1:0]          bass_code,
    output logic [ATT_W-1:0]           bass_lvl,
    output logic [TONE_W-1:0]          treble_code,
    output logic [ATT_W-1:0]           treble_lvl,
    output logic                       sel_err,
    output logic                       changed
);
    localparam int GAIN_MAX = (1 << GAIN_W) - 1;

    settings_t set_q;

    acd_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .set_o     (set_q),
        .err_o     (sel_err),
        .chg_o     (changed)
    );

    assign vol_code = set_q.vol;
    acd_att_conv #(.COARSE_W(3), .FINE_W(3), .COARSE_Q(COARSE_Q),
                   .FINE_Q(FINE_Q), .ATT_W(ATT_W)) u_vol (
        .code_i(set_q.vol),
        .att_o (vol_att)
    );

    for (genvar i = 0; i < NUM_SPK; i++) begin : g_spk
        logic [ATT_W-1:0] raw_att;
        acd_att_conv #(.COARSE_W(2), .FINE_W(3), .COARSE_Q(COARSE_Q),
                       .FINE_Q(FINE_Q), .ATT_W(ATT_W)) u_att (
            .code_i(set_q.spk[i]),
            .att_o (raw_att)
        );
        assign spk_code[i*SPK_W +: SPK_W] = set_q.spk[i];
        assign spk_mute[i]                = &set_q.spk[i];
        assign spk_att[i*ATT_W +: ATT_W]  = spk_mute[i] ? '0 : raw_att;

        p_mute_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            spk_mute[i] |-> (spk_att[i*ATT_W +: ATT_W] == '0));
    end

    assign in_sel    = set_q.sel;
    assign gain_code = set_q.gain;
    assign gain_lvl  = ATT_W'((GAIN_MAX - int'(set_q.gain)) * GAIN_Q);

    assign bass_code   = set_q.bass;
    assign treble_code = set_q.treb;

    acd_tone_conv #(.STEP_Q(TONE_Q), .ATT_W(ATT_W)) u_bass (
        .clk(clk), .rst_n(rst_n), .code_i(set_q.bass), .lvl_o(bass_lvl)
    );
    acd_tone_conv #(.STEP_Q(TONE_Q), .ATT_W(ATT_W)) u_treb (
        .clk(clk), .rst_n(rst_n), .code_i(set_q.treb), .lvl_o(treble_lvl)
    );

    p_vol_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(vol_att) <= 0) && ($signed(vol_att) >= -315));
    p_gain_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(gain_lvl) >= 0) && ($signed(gain_lvl) <= 3 * GAIN_Q));
endmodule

// File: tb/audio_cmd_decoder_tb.sv
`timescale 1ns/1ps
module audio_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [5:0]  vol_code;
    logic [9:0]  vol_att;
    logic [19:0] spk_code;
    logic [39:0] spk_att;
    logic [3:0]  spk_mute;
    logic [2:0]  in_sel;
    logic [1:0]  gain_code;
    logic [9:0]  gain_lvl;
    logic [3:0]  bass_code;
    logic [9:0]  bass_lvl;
    logic [3:0]  treble_code;
    logic [9:0]  treble_lvl;
    logic        sel_err;
    logic        changed;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    audio_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .vol_code(vol_code), .vol_att(vol_att), .spk_code(spk_code),
        .spk_att(spk_att), .spk_mute(spk_mute), .in_sel(in_sel),
        .gain_code(gain_code), .gain_lvl(gain_lvl), .bass_code(bass_code),
        .bass_lvl(bass_lvl), .treble_code(treble_code), .treble_lvl(treble_lvl),
        .sel_err(sel_err), .changed(changed)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_att(input int coarse, input int fine);
        return -(coarse * 40 + fine * 5);
    endfunction

    function automatic int exp_tone(input int c);
        if (c >= 8) return 8 * (15 - c);
        return 8 * c - 56;
    endfunction

    function automatic int spk_lvl(input int n);
        return int'($signed(spk_att[n*10 +: 10]));
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = ~b;
    endtask

    task automatic test_reset;
        check("R7", "vol_code", int'(vol_code), 62);
        check("R7", "vol_att", int'($signed(vol_att)), -310);
        for (int n = 0; n < 4; n++) begin
            check("R7", "spk_code", int'(spk_code[n*5 +: 5]), 30);
            check("R7", "spk_att", spk_lvl(n), -150);
        end
        check("R7", "spk_mute", int'(spk_mute), 0);
        check("R7", "in_sel", int'(in_sel), 4);
        check("R7", "gain_lvl", int'($signed(gain_lvl)), 0);
        check("R7", "bass_lvl", int'($signed(bass_lvl)), 8);
        check("R7", "treble_lvl", int'($signed(treble_lvl)), 8);
        check("R7", "pulses", int'({sel_err, changed}), 0);
    endtask

    task automatic test_volume;
        send(8'h00);
        check("R1", "vol 0", int'($signed(vol_att)), 0);
        check("R10", "changed", int'(changed), 1);
        send(8'h24);
        check("R1", "vol code 0x24", int'(vol_code), 8'h24);
        check("R1", "vol -45dB", int'($signed(vol_att)), -180);
        send(8'h3F);
        check("R1", "vol max", int'($signed(vol_att)), exp_att(7, 7));
        @(negedge clk);
        check("R10", "changed drops", int'(changed), 0);
    endtask

    task automatic test_speaker;
        logic [4:0] codes [4];
        codes[0] = 5'b00011; codes[1] = 5'b10100; codes[2] = 5'b01111; codes[3] = 5'b11000;
        for (int n = 0; n < 4; n++) send({1'b1, 2'(n), codes[n]});
        for (int n = 0; n < 4; n++) begin
            check("R2", "spk code", int'(spk_code[n*5 +: 5]), int'(codes[n]));
            check("R2", "spk att", spk_lvl(n),
                  exp_att(int'(codes[n][4:3]), int'(codes[n][2:0])));
        end
        send(8'hB4);
        check("R2", "RF -25dB", spk_lvl(1), -100);
        check("R2", "LF untouched", spk_lvl(0), exp_att(0, 3));
    endtask

    task automatic test_mute;
        send(8'hFF);
        check("R3", "RR mute flag", int'(spk_mute), 4'b1000);
        check("R3", "RR level", spk_lvl(3), 0);
        send(8'hE0);
        check("R3", "RR unmute", int'(spk_mute), 0);
        check("R3", "RR level 0 code", spk_lvl(3), 0);
        send(8'h9F);
        check("R3", "LF mute", int'(spk_mute), 4'b0001);
    endtask

    task automatic test_input;
        send(8'h49);
        check("R4", "sel", int'(in_sel), 1);
        check("R4", "gain code", int'(gain_code), 1);
        check("R4", "gain lvl", int'($signed(gain_lvl)), 50);
        check("R8", "no err", int'(sel_err), 0);
        send(8'h40);
        check("R4", "gain +18.75", int'($signed(gain_lvl)), 75);
        send(8'h5D);
        check("R8", "err pulse", int'(sel_err), 1);
        check("R8", "sel kept", int'(in_sel), 0);
        check("R8", "gain kept", int'(gain_code), 0);
        check("R10", "no change", int'(changed), 0);
        @(negedge clk);
        check("R8", "err drops", int'(sel_err), 0);
        send(8'h5C);
        check("R4", "input 5 gain 0", int'({in_sel, gain_code}), {3'd4, 2'd3});
    endtask

    task automatic test_tone;
        for (int c = 0; c < 16; c++) begin
            send(8'h60 | 8'(c));
            check("R5", "bass code", int'(bass_code), c);
            check("R6", "bass lvl", int'($signed(bass_lvl)), exp_tone(c));
            send(8'h70 | 8'(15 - c));
            check("R5", "treble code", int'(treble_code), 15 - c);
            check("R6", "treble lvl", int'($signed(treble_lvl)), exp_tone(15 - c));
        end
        check("R5", "bass after treble", int'(bass_code), 15);
    endtask

    task automatic test_changed_idle;
        send(8'h12);
        send(8'h12);
        check("R10", "same value no pulse", int'(changed), 0);
        @(negedge clk);
        byte_data = 8'h00;
        repeat (3) @(negedge clk);
        check("R9", "idle data ignored", int'(vol_code), 8'h12);
    endtask

    task automatic test_b2b;
        @(negedge clk);
        byte_valid = 1'b1; byte_data = 8'h01;
        @(negedge clk);
        byte_data = 8'h02;
        @(negedge clk);
        byte_data = 8'hC5;
        @(negedge clk);
        byte_valid = 1'b0;
        check("R9", "last vol wins", int'(vol_code), 2);
        check("R9", "LR applied", spk_lvl(2), exp_att(0, 5));
        check("R10", "pulse after last", int'(changed), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_volume;
        test_speaker;
        test_mute;
        test_input;
        test_tone;
        test_changed_idle;
        test_b2b;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule